// File: doc/BRIEF.md
# Omega Network Switch Controller

This block connects N processor-side ports to N memory-side ports through log2 N columns of 2x2 interchange cells, each column holding N/2 cells and fed through a perfect-shuffle wiring. In every cycle each processor port may present one request, made of a target memory port and an optional broadcast flag, together with a data word. The controller derives the state of every cell from the target address bits. It admits the requests that fit together and steers each admitted word to its memory port.

Requests are weighed in order of source port, lowest first. A request is admitted only if every cell on its path is either still free or already holds the state this request needs. Any request that disagrees with a cell already claimed is reported as blocked for that cycle and is not kept. All results are registered and appear one clock after the requests are sampled.

Top module: `omega_net`

## Requirements
- R1: While reset is high, and on the first cycle after it, `grant`, `blocked` and `mem_valid` are all zero, `mem_data` is zero and every cell state in `sw_state` is 00.
- R2: Outputs change only at a clock edge. The results for requests sampled at edge t appear after edge t and hold until edge t+1.
- R3: An admitted unicast request from source s to target d sets `mem_valid[d]` and puts the data word of source s on memory lane d.
- R4: Cell state codes are 2 bits: 00 through, 01 cross, 10 upper broadcast (upper input to both outputs) and 11 lower broadcast (lower input to both outputs). Cell j of column k sits at `sw_state[2*(k*N/2+j) +: 2]`. With 4 ports, source 0 to target 0 sets both cells on its path to 00, and source 2 to target 1 sets both cells on its path to 01.
- R5: Priority runs from the lowest source index to the highest. The lowest-numbered valid source is always admitted. A later request that needs a claimed cell in a different state is not admitted.
- R6: Routing: before column k the lane index p moves to the lane given by a one-bit left rotation of p, and it enters cell p/2 on the upper input when p is even. Target bit (log2 N - 1 - k) picks the output: 0 for upper, 1 for lower. Through means the input and output halves are equal, and cross means they differ.
- R7: A request with the broadcast flag follows normal routing up to the last column. There its cell takes upper or lower broadcast, matching the input its path arrives on, and the word reaches targets d and d XOR 1. The request is admitted only if no claimed cell disagrees.
- R8: Cells that no admitted request uses read 00.
- R9: `blocked[s]` is set exactly when source s was valid and not admitted. A source with `req_valid` low is neither admitted nor blocked, and it drives no memory lane.
- R10: A memory lane whose `mem_valid` bit is low carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_PORTS | Request present, per source |
| req_bcast | input | N_PORTS | Broadcast flag, per source |
| req_dest | input | N_PORTS*log2(N_PORTS) | Target port per source; source s uses bits [s*S +: S] |
| src_data | input | N_PORTS*DATA_W | Data word per source; source s uses bits [s*DATA_W +: DATA_W] |
| grant | output | N_PORTS | Request admitted, per source |
| blocked | output | N_PORTS | Request refused, per source |
| sw_state | output | N_PORTS*log2(N_PORTS) | 2-bit state of each cell |
| mem_valid | output | N_PORTS | Memory lane carries an admitted word |
| mem_data | output | N_PORTS*DATA_W | Data word per memory lane |

## Verification
The hardest case to reach is a broadcast whose final cell is contested. It has to lose to a lower-numbered unicast that enters the same last-column cell through the other input, and it has to win when a higher-numbered request arrives there later. Directed steps place a broadcast on source 1 alongside unicasts from sources 0 and 3 that converge on the same last-column cell. A long random run with many simultaneous requests then drives frequent partial blocking. A behavioural model in the bench, built from integer paths, predicts every output in every cycle.

// File: rtl/omega_pkg.sv
package omega_pkg;

    typedef enum logic [1:0] {
        XS_THRU  = 2'b00,
        XS_CROSS = 2'b01,
        XS_BC_UP = 2'b10,
        XS_BC_LO = 2'b11
    } xstate_e;

    // State a cell needs, given the input half the path arrives on and the
    // output half the target bit selects.
    function automatic xstate_e need_state(input logic in_lower,
                                           input logic out_lower,
                                           input logic bcast_here);
        if (bcast_here)
            return in_lower ? XS_BC_LO : XS_BC_UP;
        return (in_lower ^ out_lower) ? XS_CROSS : XS_THRU;
    endfunction

endpackage

// File: rtl/omega_xcell.sv
module omega_xcell
    import omega_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  xstate_e             state,
    input  logic [DATA_W-1:0]   in_up,
    input  logic [DATA_W-1:0]   in_lo,
    output logic [DATA_W-1:0]   out_up,
    output logic [DATA_W-1:0]   out_lo
);
    always_comb begin
        unique case (state)
            XS_THRU:  begin out_up = in_up; out_lo = in_lo; end
            XS_CROSS: begin out_up = in_lo; out_lo = in_up; end
            XS_BC_UP: begin out_up = in_up; out_lo = in_up; end
            default:  begin out_up = in_lo; out_lo = in_lo; end
        endcase
    end
endmodule

// File: rtl/omega_route_arbiter.sv
module omega_route_arbiter
    import omega_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int STAGES  = $clog2(N_PORTS)
) (
    input  logic [N_PORTS-1:0]          req_valid,
    input  logic [N_PORTS-1:0]          req_bcast,
    input  logic [N_PORTS*STAGES-1:0]   req_dest,
    output logic [N_PORTS-1:0]          grant,
    output logic [N_PORTS-1:0]          dest_mask,
    output logic [N_PORTS*STAGES-1:0]   sw_flat
);
    localparam int HALF = N_PORTS / 2;

    xstate_e    cell_st   [STAGES][HALF];
    logic       cell_used [STAGES][HALF];

    always_comb begin
        logic [STAGES-1:0] pos;
        logic [STAGES-1:0] dst;
        logic              fits;
        xstate_e           need    [STAGES];
        logic [STAGES-2:0] need_j  [STAGES];

        grant     = '0;
        dest_mask = '0;
        pos       = '0;
        dst       = '0;
        fits      = 1'b0;
        for (int k = 0; k < STAGES; k++) begin
            need[k]   = XS_THRU;
            need_j[k] = '0;
            for (int j = 0; j < HALF; j++) begin
                cell_st[k][j]   = XS_THRU;
                cell_used[k][j] = 1'b0;
            end
        end

        // Lowest source first: claimed cells bind every later request.
        for (int s = 0; s < N_PORTS; s++) begin
            if (req_valid[s]) begin
                pos  = STAGES'(s);
                dst  = req_dest[s*STAGES +: STAGES];
                fits = 1'b1;
                for (int k = 0; k < STAGES; k++) begin
                    pos       = {pos[STAGES-2:0], pos[STAGES-1]};
                    need_j[k] = pos[STAGES-1:1];
                    need[k]   = need_state(pos[0], dst[STAGES-1-k],
                                           req_bcast[s] && (k == STAGES-1));
                    if (cell_used[k][need_j[k]] && cell_st[k][need_j[k]] != need[k])
                        fits = 1'b0;
                    pos = {pos[STAGES-1:1], dst[STAGES-1-k]};
                end
                if (fits) begin
                    for (int k = 0; k < STAGES; k++) begin
                        cell_used[k][need_j[k]] = 1'b1;
                        cell_st[k][need_j[k]]   = need[k];
                    end
                    grant[s]       = 1'b1;
                    dest_mask[dst] = 1'b1;
                    if (req_bcast[s])
                        dest_mask[dst ^ STAGES'(1)] = 1'b1;
                end
            end
        end

        for (int k = 0; k < STAGES; k++)
            for (int j = 0; j < HALF; j++)
                sw_flat[2*(k*HALF+j) +: 2] = cell_st[k][j];
    end
endmodule

// File: rtl/omega_fabric.sv
module omega_fabric
    import omega_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int STAGES  = $clog2(N_PORTS),
    parameter int DATA_W  = 8
) (
    input  logic [N_PORTS*STAGES-1:0]   sw_flat,
    input  logic [N_PORTS*DATA_W-1:0]   data_in,
    output logic [N_PORTS*DATA_W-1:0]   data_out
);
    localparam int HALF = N_PORTS / 2;

    logic [DATA_W-1:0] lane [STAGES+1][N_PORTS];
    logic [DATA_W-1:0] shuf [STAGES][N_PORTS];

    for (genvar p = 0; p < N_PORTS; p++) begin : g_in
        assign lane[0][p]           = data_in[p*DATA_W +: DATA_W];
        assign data_out[p*DATA_W +: DATA_W] = lane[STAGES][p];
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        for (genvar p = 0; p < N_PORTS; p++) begin : g_shuffle
            localparam int ROT = ((p << 1) | (p >> (STAGES-1))) % N_PORTS;
            assign shuf[k][ROT] = lane[k][p];
        end
        for (genvar j = 0; j < HALF; j++) begin : g_cell
            omega_xcell #(.DATA_W(DATA_W)) u_cell (
                .state  (xstate_e'(sw_flat[2*(k*HALF+j) +: 2])),
                .in_up  (shuf[k][2*j]),
                .in_lo  (shuf[k][2*j+1]),
                .out_up (lane[k+1][2*j]),
                .out_lo (lane[k+1][2*j+1])
            );
        end
    end
endmodule

// File: rtl/omega_net.sv
module omega_net
    import omega_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int DATA_W  = 8,
    localparam int STAGES = $clog2(N_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_PORTS-1:0]          req_valid,
    input  logic [N_PORTS-1:0]          req_bcast,
    input  logic [N_PORTS*STAGES-1:0]   req_dest,
    input  logic [N_PORTS*DATA_W-1:0]   src_data,
    output logic [N_PORTS-1:0]          grant,
    output logic [N_PORTS-1:0]          blocked,
    output logic [N_PORTS*STAGES-1:0]   sw_state,
    output logic [N_PORTS-1:0]          mem_valid,
    output logic [N_PORTS*DATA_W-1:0]   mem_data
);
    logic [N_PORTS-1:0]        grant_d;
    logic [N_PORTS-1:0]        dmask_d;
    logic [N_PORTS*STAGES-1:0] sw_d;
    logic [N_PORTS*DATA_W-1:0] fab_out;
    logic [N_PORTS*DATA_W-1:0] data_d;

    omega_route_arbiter #(.N_PORTS(N_PORTS), .STAGES(STAGES)) u_arb (
        .req_valid (req_valid),
        .req_bcast (req_bcast),
        .req_dest  (req_dest),
        .grant     (grant_d),
        .dest_mask (dmask_d),
        .sw_flat   (sw_d)
    );

    omega_fabric #(.N_PORTS(N_PORTS), .STAGES(STAGES), .DATA_W(DATA_W)) u_fab (
        .sw_flat  (sw_d),
        .data_in  (src_data),
        .data_out (fab_out)
    );

    for (genvar d = 0; d < N_PORTS; d++) begin : g_mask
        assign data_d[d*DATA_W +: DATA_W] =
            dmask_d[d] ? fab_out[d*DATA_W +: DATA_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant     <= '0;
            blocked   <= '0;
            sw_state  <= '0;
            mem_valid <= '0;
            mem_data  <= '0;
        end else begin
            grant     <= grant_d;
            blocked   <= req_valid & ~grant_d;
            sw_state  <= sw_d;
            mem_valid <= dmask_d;
            mem_data  <= data_d;
        end
    end
endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
    parameter int N_PORTS = 4,
    parameter int DATA_W  = 8,
    parameter int STAGES  = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic [N_PORTS-1:0]          req_valid,
    input logic [N_PORTS-1:0]          grant,
    input logic [N_PORTS-1:0]          blocked,
    input logic [N_PORTS*STAGES-1:0]   sw_state,
    input logic [N_PORTS-1:0]          mem_valid,
    input logic [N_PORTS*DATA_W-1:0]   mem_data
);
    logic [N_PORTS-1:0]        low_oh;
    logic [N_PORTS*DATA_W-1:0] idle_bits;

    assign low_oh = req_valid & (~req_valid + 1'b1);

    always_comb begin
        idle_bits = '0;
        for (int d = 0; d < N_PORTS; d++)
            if (!mem_valid[d])
                idle_bits[d*DATA_W +: DATA_W] = mem_data[d*DATA_W +: DATA_W];
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (grant == '0 && blocked == '0 && sw_state == '0 && mem_valid == '0));

    p_grant_blocked_apart_r9: assert property (@(posedge clk) disable iff (rst)
        (grant & blocked) == '0);

    p_blocked_needs_request_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((blocked | grant) & ~$past(req_valid)) == '0);

    p_lowest_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid != '0) |=> ((grant & $past(low_oh)) != '0));

    p_idle_lane_zero_r10: assert property (@(posedge clk) disable iff (rst)
        idle_bits == '0);

    p_lanes_cover_grants_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(mem_valid) >= $countones(grant));
endmodule

bind omega_net omega_net_chk #(.N_PORTS(N_PORTS), .DATA_W(DATA_W), .STAGES(STAGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .grant     (grant),
    .blocked   (blocked),
    .sw_state  (sw_state),
    .mem_valid (mem_valid),
    .mem_data  (mem_data)
);

// File: tb/tb_omega_net.sv
module tb_omega_net;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int S  = 2;
    localparam int W  = 8;
    localparam int NSW = S * N / 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [N-1:0]       req_valid = '0;
    logic [N-1:0]       req_bcast = '0;
    logic [N*S-1:0]     req_dest  = '0;
    logic [N*W-1:0]     src_data  = '0;
    logic [N-1:0]       grant, blocked, mem_valid;
    logic [N*S-1:0]     sw_state;
    logic [N*W-1:0]     mem_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [N-1:0]   e_grant, e_blk, e_mv;
    logic [N*S-1:0] e_sw;
    logic [N*W-1:0] e_md;

    omega_net #(.N_PORTS(N), .DATA_W(W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bcast(req_bcast),
        .req_dest(req_dest), .src_data(src_data), .grant(grant),
        .blocked(blocked), .sw_state(sw_state), .mem_valid(mem_valid),
        .mem_data(mem_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: walks each request's path with integers.
    task automatic model();
        bit comm [NSW];
        int st   [NSW];
        int p_idx [S];
        int p_st  [S];
        for (int i = 0; i < NSW; i++) begin comm[i] = 0; st[i] = 0; end
        e_grant = '0; e_blk = '0; e_mv = '0; e_md = '0; e_sw = '0;
        for (int s = 0; s < N; s++) begin
            if (req_valid[s]) begin
                int pos = s;
                int dst = int'(req_dest[s*S +: S]);
                bit ok = 1;
                for (int k = 0; k < S; k++) begin
                    int low, b;
                    pos = ((pos << 1) | (pos >> (S-1))) % N;
                    low = pos % 2;
                    b = (dst >> (S-1-k)) & 1;
                    p_idx[k] = k*(N/2) + pos/2;
                    p_st[k]  = (req_bcast[s] && k == S-1) ? (2 + low) : (low ^ b);
                    if (comm[p_idx[k]] && st[p_idx[k]] != p_st[k]) ok = 0;
                    pos = (pos/2)*2 + b;
                end
                if (ok) begin
                    for (int k = 0; k < S; k++) begin
                        comm[p_idx[k]] = 1; st[p_idx[k]] = p_st[k];
                    end
                    e_grant[s] = 1'b1;
                    e_mv[dst] = 1'b1;
                    e_md[dst*W +: W] = src_data[s*W +: W];
                    if (req_bcast[s]) begin
                        e_mv[dst ^ 1] = 1'b1;
                        e_md[(dst ^ 1)*W +: W] = src_data[s*W +: W];
                    end
                end else begin
                    e_blk[s] = 1'b1;
                end
            end
        end
        for (int i = 0; i < NSW; i++) e_sw[2*i +: 2] = 2'(st[i]);
    endtask

    // Drive one set of requests away from the edge, then compare after the edge.
    task automatic apply(input logic [N-1:0] v, input logic [N-1:0] bc,
                         input logic [N*S-1:0] d, input logic [N*W-1:0] data);
        logic [N-1:0] g_before;
        g_before  = grant;
        req_valid = v; req_bcast = bc; req_dest = d; src_data = data;
        model();
        #1;
        check("R2 grant held before edge", 64'(grant), 64'(g_before));
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R5 grant", 64'(grant), 64'(e_grant));
        check("R9 blocked", 64'(blocked), 64'(e_blk));
        check("R6/R8 sw_state", 64'(sw_state), 64'(e_sw));
        check("R7 mem_valid", 64'(mem_valid), 64'(e_mv));
        check("R3/R10 mem_data", 64'(mem_data), 64'(e_md));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        // R1: outputs cleared during reset
        check("R1 grant", 64'(grant), 0);
        check("R1 sw_state", 64'(sw_state), 0);
        check("R1 mem_valid", 64'(mem_valid), 0);
        rst = 1'b0;

        // R4: source 0 -> target 0, both cells through
        apply(4'b0001, 4'b0000, {2'd0, 2'd0, 2'd0, 2'd0}, 32'h0000_00A5);
        check("R4 through path", 64'(sw_state), 64'h00);
        check("R3 lane0 data", 64'(mem_data[0 +: W]), 64'hA5);
        // R4: source 2 -> target 1, both cells cross
        apply(4'b0100, 4'b0000, {2'd0, 2'd1, 2'd0, 2'd0}, 32'h00C3_0000);
        check("R4 cross path", 64'(sw_state), 64'h11);
        // R5: both together, source 2 loses to source 0
        apply(4'b0101, 4'b0000, {2'd0, 2'd1, 2'd0, 2'd0}, 32'h00C3_00A5);
        check("R5 lower wins", 64'(grant), 64'b0001);
        check("R5 higher blocked", 64'(blocked), 64'b0100);
        // R7: source 1 broadcast to targets 2 and 3, lower broadcast at last column
        apply(4'b0010, 4'b0010, {2'd0, 2'd0, 2'd2, 2'd0}, 32'h0000_5A00);
        check("R7 broadcast states", 64'(sw_state), 64'hC4);
        check("R7 broadcast lanes", 64'(mem_valid), 64'b1100);
        // R7: broadcast loses to a lower unicast sharing its last cell
        apply(4'b0011, 4'b0010, {2'd0, 2'd0, 2'd2, 2'd3}, 32'h0000_5A11);
        // R7: broadcast wins over a later unicast on the same last cell
        apply(4'b1010, 4'b0010, {2'd2, 2'd0, 2'd2, 2'd0}, 32'h7700_5A00);
        // R9: invalid requests ignored at the ports
        apply(4'b0000, 4'b1111, {2'd3, 2'd2, 2'd1, 2'd0}, 32'hFFFF_FFFF);
        check("R9 idle grant", 64'(grant | blocked | mem_valid), 0);
        // R6: permutations, all four valid
        apply(4'b1111, 4'b0000, {2'd3, 2'd2, 2'd1, 2'd0}, 32'h4433_2211);
        apply(4'b1111, 4'b0000, {2'd0, 2'd1, 2'd2, 2'd3}, 32'h4433_2211);
        apply(4'b1111, 4'b0000, {2'd1, 2'd0, 2'd3, 2'd2}, 32'h4433_2211);

        for (int i = 0; i < 400; i++) begin
            logic [N-1:0] bc;
            bc = (($urandom % 4) == 0) ? N'($urandom) : '0;
            apply(N'($urandom), bc, (N*S)'($urandom), $urandom);
        end

        // R1: reset mid-run clears everything
        rst = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R1 reset again grant", 64'(grant), 0);
        check("R1 reset again sw", 64'(sw_state), 0);
        check("R1 reset again data", 64'(mem_data), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule